// File: doc/BRIEF.md
# Periodic Channel Threshold Monitor

This block samples a set of converter channels on its own schedule and watches the results. Each channel has a period counter. When the counter expires, the channel becomes due and the block asks the external converter for a conversion of that channel. Results come back tagged with their channel number. Each result is either recorded as a completed sample or compared against that channel's lower and upper limits. The outcome lands in a per-channel flag. The flags are ORed into a single interrupt line, which has a global mask.

Automatic scheduling only runs when the global periodic enable is on and the converter is in single-conversion mode. There are two flag policies. In the first, any result sets its channel's flag. In the second, a flag is set only when a result falls outside an enabled limit, and this policy is honoured only while scheduling is running. Software clears flags one channel at a time or all at once. Register decoding and the conversion engine sit outside the block.

Top module: `pcm_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `flags` is all zero and `irq` and `conv_req` are low.
- R2: Channel i is active when `cfg_periodic_en`=1, `cfg_continuous`=0 and `ch_mon_en[i]`=1. The channel's period field P is bits [16*i+15:16*i] of `ch_period`. The channel becomes due at the (P+1)*512-th rising edge, counting the first edge at which it is active as edge 1, and then again every (P+1)*512 edges. An inactive channel restarts its count from zero and drops any pending request that has not yet been issued.
- R3: No new request is issued while `cfg_continuous`=1 or `cfg_periodic_en`=0.
- R4: A request rises one edge after its channel becomes due. Among due channels, the lowest index is served first. `conv_req` and `conv_ch` hold until `conv_ack` is sampled high. The served channel then leaves the pending set, `conv_req` is low for one cycle, and the next pending channel is requested on the edge after that.
- R5: In every-sample mode, a result with `res_valid`=1 sets `flags[res_ch]` at the edge where it is sampled.
- R6: Window mode is in force when `cfg_irq_sel`=1 and channel scheduling is on. In window mode a result sets its flag only when `ch_lo_en[c]`=1 and data < lower limit, or `ch_hi_en[c]`=1 and data > upper limit. Channel c's limits are bits [12*c+11:12*c] of `ch_lo_lim` and `ch_hi_lim`. A value equal to a limit is inside the window.
- R7: `cfg_irq_sel`=1 has no effect while `cfg_periodic_en`=0 or `cfg_continuous`=1. In that case every result sets its flag.
- R8: `flag_clr[i]`=1 clears flag i and `flag_clr_all`=1 clears all flags, both at the next edge. A flag set by a result in the same cycle as a clear stays set.
- R9: `irq` is high exactly when some flag is set and `cfg_irq_mask`=0. The mask never changes `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_periodic_en | input | 1 | Global enable for automatic scheduling |
| cfg_continuous | input | 1 | Converter is in continuous mode (suspends scheduling) |
| cfg_irq_sel | input | 1 | 0: flag every result, 1: flag out-of-window results |
| cfg_irq_mask | input | 1 | 1 blocks `irq` |
| ch_mon_en | input | NUM_CH | Per-channel scheduling enable |
| ch_lo_en | input | NUM_CH | Per-channel lower-limit check enable |
| ch_hi_en | input | NUM_CH | Per-channel upper-limit check enable |
| ch_period | input | NUM_CH*PERIOD_W | Packed period fields, channel 0 lowest |
| ch_lo_lim | input | NUM_CH*DATA_W | Packed lower limits, channel 0 lowest |
| ch_hi_lim | input | NUM_CH*DATA_W | Packed upper limits, channel 0 lowest |
| flag_clr | input | NUM_CH | Per-channel flag clear |
| flag_clr_all | input | 1 | Clear every flag |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | CH_W | Channel of the pending request |
| conv_ack | input | 1 | Converter accepts the request |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | CH_W | Channel tag of the result |
| res_data | input | DATA_W | Conversion result |
| flags | output | NUM_CH | Per-channel flags |
| irq | output | 1 | Combined, masked interrupt |

## Verification
Each result, clear or mask change takes effect on a known cycle:
- A result or a clear changes `flags` at the edge where it is sampled.
- `irq` follows `flags` and the mask combinationally.
- A request rises one edge after its channel becomes due, which is edge (P+1)*512+1 after enabling.
- After an acknowledge, the next request appears two edges later.

The bench drives and samples at falling edges and counts edges explicitly. It checks that `conv_req` is still low at edge (P+1)*512 and high one edge later, so an off-by-one period shows up. Flag results are read at the first falling edge after the sampling edge, with a clear-all in the same cycle, so every random trial stands alone.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_REQ  = 1'b1
   } arb_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pcm_tick.sv
module pcm_tick #(
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned SCALE_LOG2 = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic [PERIOD_W-1:0] period,
   input  logic                served,
   output logic                due
);
   localparam int unsigned CNT_W = PERIOD_W + SCALE_LOG2;

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             terminal;

   // expiry when the low bits are all ones and the high bits equal the period
   assign terminal = (cnt_q == {period, {SCALE_LOG2{1'b1}}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (!active) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q <= terminal ? '0 : cnt_q + 1'b1;
         if (terminal)
            pend_q <= 1'b1;
         else if (served)
            pend_q <= 1'b0;
      end
   end

   assign due = pend_q & active;

endmodule

// File: rtl/pcm_arb.sv
module pcm_arb
   import pcm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend,
   input  logic              conv_ack,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_ch,
   output logic [NUM_CH-1:0] served
);
   arb_state_e      state_q;
   logic [CH_W-1:0] ch_q;
   logic [CH_W-1:0] pick;
   logic            any;
   logic            take;

   // lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend[i]) begin
            pick = CH_W'(i);
            any  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         ch_q    <= '0;
      end else begin
         case (state_q)
            ARB_IDLE: if (any) begin
               state_q <= ARB_REQ;
               ch_q    <= pick;
            end
            ARB_REQ: if (conv_ack) state_q <= ARB_IDLE;
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign conv_req = (state_q == ARB_REQ);
   assign conv_ch  = ch_q;
   assign take     = conv_req & conv_ack;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_served
      assign served[i] = take && (ch_q == CH_W'(i));
   end

endmodule

// File: rtl/pcm_judge.sv
module pcm_judge #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 2,
   parameter int unsigned DATA_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     window_mode,
   input  logic                     res_valid,
   input  logic [CH_W-1:0]          res_ch,
   input  logic [DATA_W-1:0]        res_data,
   input  logic [NUM_CH-1:0]        lo_en,
   input  logic [NUM_CH-1:0]        hi_en,
   input  logic [NUM_CH*DATA_W-1:0] lo_lim,
   input  logic [NUM_CH*DATA_W-1:0] hi_lim,
   input  logic [NUM_CH-1:0]        flag_clr,
   input  logic                     flag_clr_all,
   output logic [NUM_CH-1:0]        flags
);
   logic [NUM_CH-1:0] set_vec;
   logic [NUM_CH-1:0] clr_vec;
   logic [NUM_CH-1:0] flags_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [DATA_W-1:0] lo_i, hi_i;
      logic              below, above;
      assign lo_i  = lo_lim[i*DATA_W +: DATA_W];
      assign hi_i  = hi_lim[i*DATA_W +: DATA_W];
      assign below = lo_en[i] && (res_data < lo_i);
      assign above = hi_en[i] && (res_data > hi_i);
      assign set_vec[i] = res_valid && (res_ch == CH_W'(i)) &&
                          (!window_mode || below || above);
   end

   assign clr_vec = flag_clr | {NUM_CH{flag_clr_all}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_vec) | set_vec;
   end

   assign flags = flags_q;

endmodule

// File: rtl/pcm_monitor.sv
module pcm_monitor
   import pcm_pkg::*;
#(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned SCALE_LOG2 = 9,
   parameter int unsigned DATA_W     = 12,
   localparam int unsigned CH_W      = idx_width(NUM_CH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_periodic_en,
   input  logic                       cfg_continuous,
   input  logic                       cfg_irq_sel,
   input  logic                       cfg_irq_mask,
   input  logic [NUM_CH-1:0]          ch_mon_en,
   input  logic [NUM_CH-1:0]          ch_lo_en,
   input  logic [NUM_CH-1:0]          ch_hi_en,
   input  logic [NUM_CH*PERIOD_W-1:0] ch_period,
   input  logic [NUM_CH*DATA_W-1:0]   ch_lo_lim,
   input  logic [NUM_CH*DATA_W-1:0]   ch_hi_lim,
   input  logic [NUM_CH-1:0]          flag_clr,
   input  logic                       flag_clr_all,
   output logic                       conv_req,
   output logic [CH_W-1:0]            conv_ch,
   input  logic                       conv_ack,
   input  logic                       res_valid,
   input  logic [CH_W-1:0]            res_ch,
   input  logic [DATA_W-1:0]          res_data,
   output logic [NUM_CH-1:0]          flags,
   output logic                       irq
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("pcm_monitor: NUM_CH must be at least 1");
   end
   if (PERIOD_W < 1 || SCALE_LOG2 < 1) begin : g_bad_period
      $error("pcm_monitor: PERIOD_W and SCALE_LOG2 must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pcm_monitor: DATA_W must be at least 1");
   end

   logic              sched_on;
   logic              window_mode;
   logic [NUM_CH-1:0] due;
   logic [NUM_CH-1:0] served;

   assign sched_on    = cfg_periodic_en & ~cfg_continuous;
   assign window_mode = cfg_irq_sel & sched_on;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_tick
      pcm_tick #(
         .PERIOD_W   (PERIOD_W),
         .SCALE_LOG2 (SCALE_LOG2)
      ) u_tick (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (sched_on & ch_mon_en[i]),
         .period (ch_period[i*PERIOD_W +: PERIOD_W]),
         .served (served[i]),
         .due    (due[i])
      );
   end

   pcm_arb #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (due),
      .conv_ack (conv_ack),
      .conv_req (conv_req),
      .conv_ch  (conv_ch),
      .served   (served)
   );

   pcm_judge #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .DATA_W (DATA_W)
   ) u_judge (
      .clk          (clk),
      .rst_n        (rst_n),
      .window_mode  (window_mode),
      .res_valid    (res_valid),
      .res_ch       (res_ch),
      .res_data     (res_data),
      .lo_en        (ch_lo_en),
      .hi_en        (ch_hi_en),
      .lo_lim       (ch_lo_lim),
      .hi_lim       (ch_hi_lim),
      .flag_clr     (flag_clr),
      .flag_clr_all (flag_clr_all),
      .flags        (flags)
   );

   assign irq = (|flags) & ~cfg_irq_mask;

endmodule

// File: rtl/pcm_monitor_chk.sv
module pcm_monitor_chk
   import pcm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned CH_W  = idx_width(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_periodic_en,
   input logic              cfg_continuous,
   input logic              cfg_irq_sel,
   input logic              cfg_irq_mask,
   input logic              flag_clr_all,
   input logic              res_valid,
   input logic [CH_W-1:0]   res_ch,
   input logic              conv_req,
   input logic              conv_ack,
   input logic [CH_W-1:0]   conv_ch,
   input logic [NUM_CH-1:0] flags,
   input logic              irq
);
   // R1: reset leaves outputs quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (flags == '0) && !conv_req && !irq);

   // R3: no fresh request while scheduling is suspended
   a_r3_no_new_req: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_continuous || !cfg_periodic_en) && !conv_req |=> !conv_req);

   // R4: request and channel hold until accepted
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req && !conv_ack |=> conv_req && $stable(conv_ch));

   // R4: one idle cycle after acceptance
   a_r4_gap: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req && conv_ack |=> !conv_req);

   // R5, R8: every-sample result sets its flag even against a clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !cfg_irq_sel |=> flags[$past(res_ch)]);

   // R8: clear-all with no result empties the flags
   a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_all && !res_valid |=> flags == '0);

   // R9: mask blocks the interrupt
   a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_irq_mask |-> !irq);

   // R9: unmasked interrupt follows the flags
   a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_irq_mask |-> irq == (flags != '0));

endmodule

bind pcm_monitor pcm_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_periodic_en (cfg_periodic_en),
   .cfg_continuous  (cfg_continuous),
   .cfg_irq_sel     (cfg_irq_sel),
   .cfg_irq_mask    (cfg_irq_mask),
   .flag_clr_all    (flag_clr_all),
   .res_valid       (res_valid),
   .res_ch          (res_ch),
   .conv_req        (conv_req),
   .conv_ack        (conv_ack),
   .conv_ch         (conv_ch),
   .flags           (flags),
   .irq             (irq)
);

// File: tb/pcm_monitor_tb.sv
`timescale 1ns/1ps
module pcm_monitor_tb;
   localparam int NC = 4;
   localparam int PW = 16;
   localparam int DW = 12;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_periodic_en = 1'b0, cfg_continuous = 1'b0;
   logic          cfg_irq_sel = 1'b0, cfg_irq_mask = 1'b0;
   logic [NC-1:0] ch_mon_en = '0, ch_lo_en = '0, ch_hi_en = '0;
   logic [PW-1:0] per [NC];
   logic [DW-1:0] lo_l [NC];
   logic [DW-1:0] hi_l [NC];
   logic [NC-1:0] flag_clr = '0;
   logic          flag_clr_all = 1'b0;
   logic          conv_req, conv_ack = 1'b0;
   logic [CW-1:0] conv_ch;
   logic          res_valid = 1'b0;
   logic [CW-1:0] res_ch = '0;
   logic [DW-1:0] res_data = '0;
   logic [NC-1:0] flags;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pcm_monitor u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_periodic_en(cfg_periodic_en), .cfg_continuous(cfg_continuous),
      .cfg_irq_sel(cfg_irq_sel), .cfg_irq_mask(cfg_irq_mask),
      .ch_mon_en(ch_mon_en), .ch_lo_en(ch_lo_en), .ch_hi_en(ch_hi_en),
      .ch_period({per[3], per[2], per[1], per[0]}),
      .ch_lo_lim({lo_l[3], lo_l[2], lo_l[1], lo_l[0]}),
      .ch_hi_lim({hi_l[3], hi_l[2], hi_l[1], hi_l[0]}),
      .flag_clr(flag_clr), .flag_clr_all(flag_clr_all),
      .conv_req(conv_req), .conv_ch(conv_ch), .conv_ack(conv_ack),
      .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
      .flags(flags), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one cycle of result / clear stimulus, then back to idle
   task automatic pulse(input logic v, input logic [CW-1:0] c, input logic [DW-1:0] d,
                        input logic [NC-1:0] clr, input logic clr_all);
      res_valid = v; res_ch = c; res_data = d; flag_clr = clr; flag_clr_all = clr_all;
      step(1);
      res_valid = 1'b0; flag_clr = '0; flag_clr_all = 1'b0;
   endtask

   task automatic ack_once();
      conv_ack = 1'b1;
      step(1);
      conv_ack = 1'b0;
   endtask

   function automatic logic exp_hit(input logic win, input logic le, input logic he,
                                    input logic [DW-1:0] d, input logic [DW-1:0] lo,
                                    input logic [DW-1:0] hi);
      if (!win) return 1'b1;
      return (le && d < lo) || (he && d > hi);
   endfunction

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) begin
         per[i] = '0; lo_l[i] = '0; hi_l[i] = 12'hFFF;
      end
      void'($urandom(32'd2024));
      step(3);
      chk("R1 flags in reset", flags, 0);
      chk("R1 irq in reset", irq, 0);
      chk("R1 req in reset", conv_req, 0);
      rst_n = 1'b1;
      step(1);
      chk("R1 flags after reset", flags, 0);

      // R5: plain result sets its flag
      pulse(1, 2, 12'h123, '0, 0);
      chk("R5 flag set", flags, 4'b0100);
      chk("R9 irq raised", irq, 1);
      cfg_irq_mask = 1'b1; #1;
      chk("R9 irq masked", irq, 0);
      chk("R9 mask keeps flags", flags, 4'b0100);
      cfg_irq_mask = 1'b0; #1;
      chk("R9 irq unmasked", irq, 1);

      // R8: clears and set-wins
      pulse(0, 0, 0, 4'b0100, 0);
      chk("R8 per-channel clear", flags, 0);
      pulse(1, 1, 12'h010, '0, 0);
      pulse(1, 3, 12'h020, '0, 0);
      chk("R8 two flags", flags, 4'b1010);
      pulse(1, 0, 12'h030, '0, 1);
      chk("R8 clear-all with set", flags, 4'b0001);
      pulse(1, 0, 12'h040, 4'b0001, 0);
      chk("R8 same-channel set wins", flags, 4'b0001);
      pulse(0, 0, 0, 4'b0001, 0);
      chk("R8 clear last", flags, 0);

      // R7: window select ignored while scheduling is off
      cfg_irq_sel = 1'b1; ch_lo_en = '1; ch_hi_en = '1;
      pulse(1, 1, 12'h800, '0, 1);
      chk("R7 sel ignored, periodic off", flags, 4'b0010);
      cfg_periodic_en = 1'b1; cfg_continuous = 1'b1;
      pulse(1, 2, 12'h800, '0, 1);
      chk("R7 sel ignored, continuous", flags, 4'b0100);
      cfg_continuous = 1'b0;

      // R6: directed boundaries on channel 0
      lo_l[0] = 12'h100; hi_l[0] = 12'h200;
      pulse(1, 0, 12'h100, '0, 1);
      chk("R6 equal lower inside", flags, 0);
      pulse(1, 0, 12'h200, '0, 1);
      chk("R6 equal upper inside", flags, 0);
      pulse(1, 0, 12'h0FF, '0, 1);
      chk("R6 below lower", flags, 4'b0001);
      pulse(1, 0, 12'h201, '0, 1);
      chk("R6 above upper", flags, 4'b0001);
      ch_lo_en[0] = 1'b0;
      pulse(1, 0, 12'h0FF, '0, 1);
      chk("R6 lower disabled", flags, 0);
      ch_hi_en[0] = 1'b0;
      pulse(1, 0, 12'h201, '0, 1);
      chk("R6 upper disabled", flags, 0);

      // R5/R6 random trials against the bench model
      for (int t = 0; t < 300; t++) begin
         int unsigned c;
         logic [DW-1:0] d;
         logic win;
         c = $urandom % NC;
         lo_l[c] = DW'($urandom);
         hi_l[c] = DW'($urandom);
         ch_lo_en[c] = 1'($urandom);
         ch_hi_en[c] = 1'($urandom);
         cfg_irq_sel = 1'($urandom);
         win = cfg_irq_sel;
         case ($urandom % 5)
            0: d = lo_l[c];
            1: d = hi_l[c];
            2: d = lo_l[c] - 1'b1;
            3: d = hi_l[c] + 1'b1;
            default: d = DW'($urandom);
         endcase
         pulse(1, CW'(c), d, '0, 1);
         chk(win ? "R6 random window" : "R5 random every-sample", flags,
             exp_hit(win, ch_lo_en[c], ch_hi_en[c], d, lo_l[c], hi_l[c]) ? (32'd1 << c) : 32'd0);
      end
      pulse(0, 0, 0, '0, 1);
      cfg_irq_sel = 1'b0;

      // R2: period 0 on channel 1
      per[1] = 16'd0;
      ch_mon_en = 4'b0010;
      step(512);
      chk("R2 not yet due at edge 512", conv_req, 0);
      step(1);
      chk("R2 request at edge 513", conv_req, 1);
      chk("R2 request channel", conv_ch, 1);
      ack_once();
      chk("R4 req drops after ack", conv_req, 0);
      step(510);
      chk("R2 second period not early", conv_req, 0);
      step(1);
      chk("R2 second period request", conv_req, 1);
      ack_once();
      ch_mon_en = '0;
      step(2);

      // R2: period 1 on channel 3
      per[3] = 16'd1;
      ch_mon_en = 4'b1000;
      step(1024);
      chk("R2 period 1 not early", conv_req, 0);
      step(1);
      chk("R2 period 1 request", conv_req, 1);
      chk("R2 period 1 channel", conv_ch, 3);
      ack_once();
      ch_mon_en = '0;
      per[3] = 16'd0;
      step(2);

      // R2: disabling drops a pending request before it is issued
      ch_mon_en = 4'b0001;
      step(512);
      ch_mon_en = '0;
      step(5);
      chk("R2 pending dropped on disable", conv_req, 0);

      // R4: all channels due together
      ch_mon_en = 4'b1111;
      step(513);
      chk("R4 first served", conv_req, 1);
      chk("R4 lowest channel first", conv_ch, 0);
      step(3);
      chk("R4 request held", conv_req, 1);
      chk("R4 channel held", conv_ch, 0);
      ack_once();
      for (int k = 1; k < NC; k++) begin
         chk("R4 gap after ack", conv_req, 0);
         step(1);
         chk("R4 next request", conv_req, 1);
         chk("R4 priority order", conv_ch, k);
         ack_once();
      end
      chk("R4 idle after last", conv_req, 0);
      ch_mon_en = '0;
      step(2);

      // R3: scheduling suspended
      begin
         int seen;
         seen = 0;
         cfg_continuous = 1'b1;
         ch_mon_en = 4'b1111;
         for (int k = 0; k < 1100; k++) begin
            step(1);
            if (conv_req) seen++;
         end
         chk("R3 no request in continuous mode", seen, 0);
         seen = 0;
         cfg_continuous = 1'b0;
         cfg_periodic_en = 1'b0;
         for (int k = 0; k < 600; k++) begin
            step(1);
            if (conv_req) seen++;
         end
         chk("R3 no request with periodic off", seen, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule